// File: doc/BRIEF.md
# Dataflow loop iteration controller

This block sequences a repeated loop body in a dataflow-style hardware design. Software-style loops compile into a body of logic that is told when to begin (`body_start`) and that reports when it has finished (`body_done`). The controller issues those start pulses and waits for each completion. Between iterations it keeps a fixed gap. It decides when the loop is over and then pulses `done`. Two loop styles share the same sequencer. A count loop runs a given number of trips. A condition loop repeats until the body raises `stop_flag` together with its completion.

Values carried from one iteration to the next live in a bank of registers inside the controller, one per carried value, each `CW` bits wide. When the `HAS_INIT` parameter is set, the bank is loaded from `init_vals` during one extra cycle before the first iteration. When it is clear, that cycle is left out and the bank keeps whatever it last held. On every completion the bank captures the body's `body_next` outputs. The controller also presents a signed iteration index that stops at its largest positive value instead of wrapping.

Top module: `loop_iter_ctrl`

## Requirements
- R1: `iter_idx` is a signed `IDX_W`-bit value that saturates at 2^(IDX_W-1)-1 (2^31-1 by default). It holds there on further completions and never becomes negative.
- R2: Let `body_done` be sampled high in cycle k, ending an iteration that is not the last. The next `body_start` is then high in cycle k+3, so exactly two idle controller cycles lie between them.
- R3: Let a run be accepted in cycle s, with `start` high while idle, and let it perform at least one iteration. With `HAS_INIT`=1, cycle s+1 loads the carried registers and the first `body_start` is in cycle s+2. With `HAS_INIT`=0, the first `body_start` is in cycle s+1.
- R4: `body_start` is never high for two cycles in a row. `start` is accepted only while the controller is idle, so a `start` pulse in a busy cycle or in a `done` cycle has no effect on the running loop.
- R5: With `mode`=0 (count loop) and `count` > 0, exactly `count` iterations run. `stop_flag` has no effect in this mode.
- R6: With `mode`=0 and `count` <= 0 (signed), no `body_start` is issued. `done` is high in cycle s+1, and the carried registers are not loaded.
- R7: With `mode`=1 (condition loop), at least one iteration runs. The loop ends after the iteration whose `body_done` cycle has `stop_flag` high, and `stop_flag` is ignored in cycles where `body_done` is low.
- R8: `done` is high for exactly one cycle, the cycle after the final `body_done`. `busy` is high from cycle s+1 until the cycle before `done`, and it is low while `done` is high.
- R9: `iter_idx` is 0 from cycle s+1 through the first iteration. It increases by one in the cycle after each `body_done` of the run, subject to R1, and keeps its value while idle.
- R10: Carried lane g occupies bits [g*CW +: CW] of `init_vals`, `body_next` and `carry_out`. The load cycle of R3 copies `init_vals`, and each `body_done` cycle copies `body_next`. The value appears on `carry_out` one cycle later and is held between those events, including after `done`.
- R11: A synchronous reset `rst` returns the controller to idle. In the following cycle `busy`, `done` and `body_start` are low, and `iter_idx` and `carry_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a loop run (honoured only when idle) |
| mode | input | 1 | 0 = count loop, 1 = condition loop |
| count | input | CNT_W | Signed trip count for the count loop |
| init_vals | input | NC*CW | Initial values of the carried registers |
| body_start | output | 1 | One-cycle pulse launching an iteration of the body |
| body_done | input | 1 | Body reports the current iteration finished |
| stop_flag | input | 1 | Condition-loop exit request, sampled with `body_done` |
| body_next | input | NC*CW | Carried values produced by the body |
| carry_out | output | NC*CW | Current contents of the carried registers |
| iter_idx | output | IDX_W | Signed saturating iteration index |
| busy | output | 1 | A loop run is in progress |
| done | output | 1 | One-cycle pulse after the final iteration |

## Verification
A single `body_done` cycle does several jobs at once: it captures the carried values, advances the index and makes the exit decision. The hardest case is when that cycle also falls on the saturation boundary or on a `stop_flag` that must be ignored. Condition runs of up to twelve iterations are swept against a four-bit index, so many completions land on an already saturated index. `stop_flag` is held high in every non-completion cycle and in every completion cycle of a count run. In each cycle the bench predicts the index, the carry contents, the start pulses and `done` from the trip arithmetic. It flags any cycle where the capture, the saturation or the exit decision interfere with one another.

// File: rtl/loop_ctrl_pkg.sv
package loop_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_INIT   = 3'd1,
    ST_LAUNCH = 3'd2,
    ST_WAIT   = 3'd3,
    ST_GAP1   = 3'd4,
    ST_GAP2   = 3'd5,
    ST_FIN    = 3'd6
  } lc_state_e;

  localparam logic MODE_COUNT = 1'b0;
  localparam logic MODE_COND  = 1'b1;

endpackage

// File: rtl/loop_seq.sv
module loop_seq
  import loop_ctrl_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit HAS_INIT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    mode,
  input  logic signed [CNT_W-1:0] count,
  input  logic                    body_done,
  input  logic                    stop_flag,
  output logic                    body_start,
  output logic                    busy,
  output logic                    done,
  output logic                    evt_accept,
  output logic                    evt_zero,
  output logic                    evt_load,
  output logic                    evt_capture,
  output logic                    evt_last
);

  localparam logic signed [CNT_W-1:0] TRIP_ONE = CNT_W'(1);

  lc_state_e               state;
  logic                    mode_q;
  logic signed [CNT_W-1:0] remain;
  logic                    final_trip;

  // a count loop with a non-positive trip count never launches the body
  function automatic logic trips_empty(input logic signed [CNT_W-1:0] n);
    return n <= $signed(CNT_W'(0));
  endfunction

  // exit decision taken on the completion cycle
  function automatic logic is_final(input logic md,
                                    input logic stp,
                                    input logic signed [CNT_W-1:0] left);
    return (md == MODE_COND) ? stp : (left == TRIP_ONE);
  endfunction

  assign evt_accept  = (state == ST_IDLE) && start;
  assign evt_zero    = evt_accept && (mode == MODE_COUNT) && trips_empty(count);
  assign evt_load    = (state == ST_INIT);
  assign evt_capture = (state == ST_WAIT) && body_done;
  assign final_trip  = is_final(mode_q, stop_flag, remain);
  assign evt_last    = evt_capture && final_trip;

  assign body_start  = (state == ST_LAUNCH);
  assign done        = (state == ST_FIN);
  assign busy        = (state != ST_IDLE) && (state != ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      mode_q <= MODE_COUNT;
      remain <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q <= mode;
            remain <= count;
            if (evt_zero) begin
              state <= ST_FIN;
            end else if (HAS_INIT) begin
              state <= ST_INIT;
            end else begin
              state <= ST_LAUNCH;
            end
          end
        end
        ST_INIT:   state <= ST_LAUNCH;
        ST_LAUNCH: state <= ST_WAIT;
        ST_WAIT: begin
          if (body_done) begin
            if (mode_q == MODE_COUNT) begin
              remain <= remain - TRIP_ONE;
            end
            state <= final_trip ? ST_FIN : ST_GAP1;
          end
        end
        ST_GAP1:   state <= ST_GAP2;
        ST_GAP2:   state <= ST_LAUNCH;
        ST_FIN:    state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/loop_index.sv
module loop_index #(
  parameter int IDX_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    step,
  output logic signed [IDX_W-1:0] idx
);

  localparam logic signed [IDX_W-1:0] IDX_MAX = {1'b0, {(IDX_W-1){1'b1}}};
  localparam logic signed [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  // increment that sticks at the largest positive value
  function automatic logic signed [IDX_W-1:0] sat_step(input logic signed [IDX_W-1:0] v);
    return (v == IDX_MAX) ? v : v + IDX_ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx <= '0;
    end else if (step) begin
      idx <= sat_step(idx);
    end
  end

endmodule

// File: rtl/loop_carry.sv
module loop_carry #(
  parameter int CW       = 32,
  parameter int NC       = 2,
  parameter bit HAS_INIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             capture,
  input  logic [NC*CW-1:0] init_vals,
  input  logic [NC*CW-1:0] next_vals,
  output logic [NC*CW-1:0] vals
);

  for (genvar g = 0; g < NC; g++) begin : g_lane
    logic [CW-1:0] lane_q;

    if (HAS_INIT) begin : g_init
      always_ff @(posedge clk) begin
        if (rst) begin
          lane_q <= '0;
        end else if (load) begin
          lane_q <= init_vals[g*CW +: CW];
        end else if (capture) begin
          lane_q <= next_vals[g*CW +: CW];
        end
      end
    end else begin : g_noinit
      logic unused_load;
      assign unused_load = load ^ (^init_vals[g*CW +: CW]);
      always_ff @(posedge clk) begin
        if (rst) begin
          lane_q <= '0;
        end else if (capture) begin
          lane_q <= next_vals[g*CW +: CW];
        end
      end
    end

    assign vals[g*CW +: CW] = lane_q;
  end

endmodule

// File: rtl/loop_iter_ctrl.sv
module loop_iter_ctrl #(
  parameter int CW       = 32,
  parameter int NC       = 2,
  parameter int IDX_W    = 32,
  parameter int CNT_W    = 32,
  parameter bit HAS_INIT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    mode,
  input  logic signed [CNT_W-1:0] count,
  input  logic [NC*CW-1:0]        init_vals,
  output logic                    body_start,
  input  logic                    body_done,
  input  logic                    stop_flag,
  input  logic [NC*CW-1:0]        body_next,
  output logic [NC*CW-1:0]        carry_out,
  output logic signed [IDX_W-1:0] iter_idx,
  output logic                    busy,
  output logic                    done
);

  logic evt_accept;
  logic evt_zero;
  logic evt_load;
  logic evt_capture;
  logic evt_last;

  loop_seq #(
    .CNT_W   (CNT_W),
    .HAS_INIT(HAS_INIT)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mode       (mode),
    .count      (count),
    .body_done  (body_done),
    .stop_flag  (stop_flag),
    .body_start (body_start),
    .busy       (busy),
    .done       (done),
    .evt_accept (evt_accept),
    .evt_zero   (evt_zero),
    .evt_load   (evt_load),
    .evt_capture(evt_capture),
    .evt_last   (evt_last)
  );

  loop_index #(
    .IDX_W(IDX_W)
  ) u_index (
    .clk  (clk),
    .rst  (rst),
    .clear(evt_accept),
    .step (evt_capture),
    .idx  (iter_idx)
  );

  loop_carry #(
    .CW      (CW),
    .NC      (NC),
    .HAS_INIT(HAS_INIT)
  ) u_carry (
    .clk      (clk),
    .rst      (rst),
    .load     (evt_load),
    .capture  (evt_capture),
    .init_vals(init_vals),
    .next_vals(body_next),
    .vals     (carry_out)
  );

endmodule

// File: rtl/loop_iter_ctrl_chk.sv
module loop_iter_ctrl_chk #(
  parameter int CW       = 32,
  parameter int NC       = 2,
  parameter int IDX_W    = 32,
  parameter bit HAS_INIT = 1'b1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    body_start,
  input logic                    busy,
  input logic                    done,
  input logic signed [IDX_W-1:0] iter_idx,
  input logic [NC*CW-1:0]        init_vals,
  input logic [NC*CW-1:0]        carry_out,
  input logic                    evt_accept,
  input logic                    evt_zero,
  input logic                    evt_load,
  input logic                    evt_capture,
  input logic                    evt_last
);

  localparam logic signed [IDX_W-1:0] IDX_MAX = {1'b0, {(IDX_W-1){1'b1}}};
  localparam logic signed [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  assert_idx_nonneg_R1: assert property (@(posedge clk) disable iff (rst)
    !iter_idx[IDX_W-1]);

  assert_idx_sat_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (iter_idx == IDX_MAX && !evt_accept) |=> (iter_idx == IDX_MAX));

  assert_gap_two_R2: assert property (@(posedge clk) disable iff (rst)
    (evt_capture && !evt_last) |=> !body_start ##1 !body_start ##1 body_start);

  if (HAS_INIT) begin : g_init_chk
    assert_init_cycle_R3: assert property (@(posedge clk) disable iff (rst)
      (evt_accept && !evt_zero) |=> evt_load ##1 body_start);
  end else begin : g_noinit_chk
    assert_no_init_cycle_R3: assert property (@(posedge clk) disable iff (rst)
      (evt_accept && !evt_zero) |=> (body_start && !evt_load));
  end

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    body_start |=> !body_start);

  assert_zero_trip_R6: assert property (@(posedge clk) disable iff (rst)
    evt_zero |=> (done && !body_start && !evt_load));

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    evt_last |=> (done && !busy));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idx_step_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_capture && iter_idx != IDX_MAX) |=> (iter_idx == $past(iter_idx) + IDX_ONE));

  assert_load_init_R10: assert property (@(posedge clk) disable iff (rst)
    evt_load |=> (carry_out == $past(init_vals)));

  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> (!busy && !done && !body_start && iter_idx == '0 && carry_out == '0));

endmodule

bind loop_iter_ctrl loop_iter_ctrl_chk #(
  .CW      (CW),
  .NC      (NC),
  .IDX_W   (IDX_W),
  .HAS_INIT(HAS_INIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .body_start (body_start),
  .busy       (busy),
  .done       (done),
  .iter_idx   (iter_idx),
  .init_vals  (init_vals),
  .carry_out  (carry_out),
  .evt_accept (evt_accept),
  .evt_zero   (evt_zero),
  .evt_load   (evt_load),
  .evt_capture(evt_capture),
  .evt_last   (evt_last)
);

// File: tb/loop_iter_ctrl_tb.sv
`timescale 1ns/1ps
module loop_iter_ctrl_tb;
  localparam int CW    = 8;
  localparam int NC    = 2;
  localparam int IDX_W = 4;
  localparam int CNT_W = 8;
  localparam int IMAX  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic signed [CNT_W-1:0] count = '0;
  logic [NC*CW-1:0] init_vals = '0;

  logic bd_a = 1'b0, sf_a = 1'b0, bs_a, busy_a, done_a;
  logic [NC*CW-1:0] nx_a = '0, cy_a;
  logic signed [IDX_W-1:0] ix_a;

  logic bd_b = 1'b0, sf_b = 1'b0, bs_b, busy_b, done_b;
  logic [NC*CW-1:0] nx_b = '0, cy_b;
  logic signed [IDX_W-1:0] ix_b;

  int vectors = 0;
  int errors = 0;
  logic [NC*CW-1:0] exp_a = '0, exp_b = '0;

  always #2.5 clk = ~clk;

  loop_iter_ctrl #(.CW(CW), .NC(NC), .IDX_W(IDX_W), .CNT_W(CNT_W), .HAS_INIT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .count(count), .init_vals(init_vals),
    .body_start(bs_a), .body_done(bd_a), .stop_flag(sf_a), .body_next(nx_a),
    .carry_out(cy_a), .iter_idx(ix_a), .busy(busy_a), .done(done_a));

  loop_iter_ctrl #(.CW(CW), .NC(NC), .IDX_W(IDX_W), .CNT_W(CNT_W), .HAS_INIT(1'b0)) u_dut2 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .count(count), .init_vals(init_vals),
    .body_start(bs_b), .body_done(bd_b), .stop_flag(sf_b), .body_next(nx_b),
    .carry_out(cy_b), .iter_idx(ix_b), .busy(busy_b), .done(done_b));

  task automatic chk(input string tag, input longint act, input longint expv);
    vectors++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [NC*CW-1:0] pat(input int i, input int run);
    logic [NC*CW-1:0] v;
    for (int g = 0; g < NC; g++) v[g*CW +: CW] = 8'((i * 7 + g * 3 + run * 11) & 255);
    return v;
  endfunction

  // iteration number whose event (start: off=0, completion: off=lat) is in cycle c, else -1
  function automatic int slot(input int c, input int b0, input int off, input int p, input int n);
    int d = c - b0 - off;
    if (d < 0 || (d % p) != 0 || (d / p) >= n) return -1;
    return d / p;
  endfunction

  function automatic int completed(input int c, input int b0, input int lat, input int p, input int n);
    int k = 0;
    for (int i = 0; i < n; i++) if (b0 + i * p + lat < c) k++;
    return (k > IMAX) ? IMAX : k;
  endfunction

  task automatic run_case(input bit md, input int cnt, input int stopat, input int lat,
                          input bit spur, input int run);
    int n, p, fin_a, fin_b, ia, ib;
    string tm;
    n = md ? stopat + 1 : ((cnt > 0) ? cnt : 0);
    p = lat + 3;
    fin_a = (n == 0) ? 1 : 2 + (n - 1) * p + lat + 1;
    fin_b = (n == 0) ? 1 : 1 + (n - 1) * p + lat + 1;
    tm = md ? "R7" : ((cnt > 0) ? "R5" : "R6");
    for (int c = 0; c <= fin_a + 1; c++) begin
      @(negedge clk);
      if (c > 0) begin
        chk({tm, " R2 R3 R4 body_start A"}, bs_a, slot(c, 2, 0, p, n) >= 0);
        chk({tm, " R8 done A"}, done_a, c == fin_a);
        chk({tm, " R8 R4 busy A"}, busy_a, c < fin_a);
        chk({tm, " R9 R1 iter_idx A"}, ix_a, completed(c, 2, lat, p, n));
        chk({tm, " R10 carry A"}, cy_a, exp_a);
        chk({tm, " R2 R3 R4 body_start B"}, bs_b, slot(c, 1, 0, p, n) >= 0);
        chk({tm, " R8 done B"}, done_b, c == fin_b);
        chk({tm, " R8 R4 busy B"}, busy_b, c < fin_b);
        chk({tm, " R9 R1 iter_idx B"}, ix_b, completed(c, 1, lat, p, n));
        chk({tm, " R10 carry B"}, cy_b, exp_b);
      end
      start = (c == 0) || (spur && c == 3 && n > 0);
      mode  = (spur && c == 3) ? 1'b0 : md;
      count = (spur && c == 3) ? '0 : CNT_W'(cnt);
      if (c == 0) init_vals = pat(50, run);
      ia = slot(c, 2, lat, p, n);
      bd_a = (ia >= 0);
      nx_a = pat(ia, run);
      sf_a = (ia >= 0) ? (md ? (ia == stopat) : 1'b1) : 1'b1;
      ib = slot(c, 1, lat, p, n);
      bd_b = (ib >= 0);
      nx_b = pat(ib + 20, run);
      sf_b = (ib >= 0) ? (md ? (ib == stopat) : 1'b1) : 1'b1;
      if (c == 1 && n > 0) exp_a = init_vals;
      if (ia >= 0) exp_a = pat(ia, run);
      if (ib >= 0) exp_b = pat(ib + 20, run);
    end
    start = 1'b0; bd_a = 1'b0; bd_b = 1'b0; sf_a = 1'b0; sf_b = 1'b0;
  endtask

  task automatic reset_mid();
    @(negedge clk);
    start = 1'b1; mode = 1'b0; count = CNT_W'(5); init_vals = pat(3, 9);
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 busy before reset", busy_a, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 busy A", busy_a, 0);
    chk("R11 busy B", busy_b, 0);
    chk("R11 done A", done_a, 0);
    chk("R11 body_start A", bs_a, 0);
    chk("R11 iter_idx A", ix_a, 0);
    chk("R11 iter_idx B", ix_b, 0);
    chk("R11 carry A", cy_a, 0);
    chk("R11 carry B", cy_b, 0);
    exp_a = '0; exp_b = '0;
    @(negedge clk);
    chk("R11 stays idle A", busy_a, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : main
    int run = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset busy", busy_a, 0);
    chk("R11 reset done", done_a, 0);
    chk("R11 reset body_start", bs_a, 0);
    chk("R11 reset iter_idx", ix_a, 0);
    chk("R11 reset carry", cy_a, 0);
    for (int lat = 1; lat <= 3; lat++) begin
      for (int cnt = -2; cnt <= 9; cnt++) begin
        run_case(1'b0, cnt, 0, lat, lat == 2, run);
        run++;
      end
      for (int st = 0; st <= 11; st++) begin
        run_case(1'b1, 3, st, lat, lat == 3, run);
        run++;
      end
    end
    run_case(1'b0, 12, 0, 1, 1'b0, run);
    reset_mid();
    run_case(1'b1, 0, 1, 2, 1'b1, run + 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule